// File: doc/BRIEF.md
# Serial Boot Source Scan Sequencer

This block chooses where a device starts executing after reset. On the first cycle after reset it latches two application-programmed flags, a boot-selection word and a pin-map word from nonvolatile storage. When both flags are set, it boots from local memory and pulses a start-execution strobe. When either flag is clear, it works through an ordered list of serial boot attempts. For each attempt it names a loader path and raises an enable, then waits for a done, a fail or its own step timeout.

The boot-selection word can replace the default list with a preferred route. That route first tries one chosen UART and then an SPI boot on pins described by the pin-map word. If the SPI boot fails, the block falls back to the full default list. The block also gates the reset function of the shared pad 0 while an attempt drives data on that pad, and it enables the debug port once every attempt has failed.

Top module: `boot_scan_seq`

## Requirements
- R1: While reset is asserted, the outputs are as follows: `ld_en`=0, `ld_path`=0, `start_exec`=0, `boot_done`=0, `halted`=0, `dbg_en`=0 and `rst_pin_en`=1.
- R2: When both `app_flag_a` and `app_flag_b` are 1 at the sampling cycle, no attempt is made (`ld_en` stays 0). On the cycle after sampling, `boot_done`=1, `boot_local`=1 and `start_exec`=1.
- R3: Otherwise the attempts come in this order of `ld_path` codes: 1 (host-driven SPI), 2 (one-wire UART on pad 5), 3 (one-wire UART on pad 3), 4 (two-wire UART on pads 0/1), 5 (SPI to an external memory), 6 (I2C memory).
- R4: When the last attempt in the order fails, `halted`=1 and `dbg_en`=1 from the next cycle onward, and `ld_en` stays 0.
- R5: An attempt with no response keeps `ld_en` high for exactly `step_timeout` cycles and then counts as a failure. A `step_timeout` of 0 disables the timeout.
- R6: A `ld_done` during an attempt ends the scan. On the next cycle `boot_done`=1, `ld_en`=0 and `start_exec`=1 for exactly one cycle. Later `ld_done`/`ld_fail` pulses have no effect.
- R7: When `boot_cfg[7:0]`=0xAA, the first attempt is a UART chosen by `boot_cfg[31:24]`: 0x00 gives code 4, 0x01 gives code 3, 0x02 gives code 2, and any other value gives code 4. The second attempt is code 7 (SPI on mapped pins, `cust_pins`=1). Any other `boot_cfg[7:0]` value runs the default order.
- R8: When the code 7 attempt fails, the scan continues with the full default order 1 to 6.
- R9: `pin_map` is split into four bytes. Each byte has its port number in the upper nibble and its pin number in the lower nibble. Bits [7:0] go to `sck_*`, bits [15:8] to `cs_*`, bits [23:16] to `dout_*` and bits [31:24] to `din_*`.
- R10: `wake_op` carries `boot_cfg[15:8]` and `spi_div` carries `boot_cfg[23:16]`, both as latched at the sampling cycle.
- R11: `rst_pin_en` is 0 during an attempt with code 1, 4 or 5. It is also 0 during a code 7 attempt when any `pin_map` byte equals 0x00. It is 1 at all other times.
- R12: Between a failed attempt and the next one, `ld_en` is low for exactly one cycle.
- R13: When `ld_done` and `ld_fail` arrive in the same cycle, `ld_done` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| app_flag_a | input | 1 | First application-programmed flag |
| app_flag_b | input | 1 | Second application-programmed flag |
| boot_cfg | input | 32 | Boot-selection word |
| pin_map | input | 32 | Mapped SPI pin word |
| step_timeout | input | TMO_W | Cycles allowed per attempt, 0 means no limit |
| ld_done | input | 1 | Loader reports success |
| ld_fail | input | 1 | Loader reports failure |
| ld_en | output | 1 | Loader enable for the current attempt |
| ld_path | output | 3 | Code of the current attempt, 0 when idle |
| cust_pins | output | 1 | Pin mux uses the mapped SPI pins |
| sck_port | output | 4 | Clock port number |
| sck_pin | output | 4 | Clock pin number |
| cs_port | output | 4 | Chip-enable port number |
| cs_pin | output | 4 | Chip-enable pin number |
| dout_port | output | 4 | Data-out port number |
| dout_pin | output | 4 | Data-out pin number |
| din_port | output | 4 | Data-in port number |
| din_pin | output | 4 | Data-in pin number |
| wake_op | output | 8 | Wake-up opcode for the SPI loader |
| spi_div | output | 8 | SPI clock divider for the SPI loader |
| rst_pin_en | output | 1 | Reset function enable of shared pad 0 |
| dbg_en | output | 1 | Debug port enable |
| boot_local | output | 1 | Booting from local memory |
| boot_done | output | 1 | A boot source was found |
| halted | output | 1 | Every attempt failed |
| start_exec | output | 1 | One-cycle start-execution pulse |

## Verification
The bench builds the block with its defaults: `TMO_W`=16 and the preferred route compiled in (`CUSTOM_EN`=1). Because the timeout is a port rather than a parameter, each scenario picks its own limit. A limit of 5 checks the exact length of a timed-out attempt, a large limit lets fail pulses drive every attempt, and a limit of 0 shows that the watchdog is off. With the preferred route compiled in, the eight-entry order, every UART selector value and the fallback from the mapped SPI attempt are all reachable.

// File: rtl/boot_scan_pkg.sv
package boot_scan_pkg;

   localparam int PATH_W = 3;
   localparam int IDX_W  = 3;

   // loader path codes (order of the default scan is 1..6)
   localparam logic [PATH_W-1:0] P_NONE     = 3'd0;
   localparam logic [PATH_W-1:0] P_SPI_HOST = 3'd1;
   localparam logic [PATH_W-1:0] P_UART1_P5 = 3'd2;
   localparam logic [PATH_W-1:0] P_UART1_P3 = 3'd3;
   localparam logic [PATH_W-1:0] P_UART2    = 3'd4;
   localparam logic [PATH_W-1:0] P_SPI_DEV  = 3'd5;
   localparam logic [PATH_W-1:0] P_I2C      = 3'd6;
   localparam logic [PATH_W-1:0] P_SPI_CUST = 3'd7;

   localparam logic [7:0] SEL_CUSTOM = 8'hAA;

   typedef enum logic [2:0] {
      S_SAMPLE,
      S_ATTEMPT,
      S_GAP,
      S_DONE,
      S_HALT
   } state_e;

   typedef struct packed {
      logic [3:0] port;
      logic [3:0] pin;
   } pinsel_t;

endpackage

// File: rtl/boot_cfg_decode.sv
module boot_cfg_decode
   import boot_scan_pkg::*;
(
   input  logic [31:0]       cfg,
   input  logic [31:0]       map,
   output logic              custom,
   output logic [PATH_W-1:0] uart_path,
   output logic [7:0]        wake_op,
   output logic [7:0]        spi_div,
   output pinsel_t           sck,
   output pinsel_t           cs,
   output pinsel_t           dout,
   output pinsel_t           din,
   output logic              map_on_p0
);

   localparam int N_SIG = 4;

   logic [N_SIG-1:0] hit_p0;

   assign custom  = (cfg[7:0] == SEL_CUSTOM);
   assign wake_op = cfg[15:8];
   assign spi_div = cfg[23:16];

   always_comb begin
      unique case (cfg[31:24])
         8'h01:   uart_path = P_UART1_P3;
         8'h02:   uart_path = P_UART1_P5;
         default: uart_path = P_UART2;
      endcase
   end

   assign sck  = pinsel_t'(map[7:0]);
   assign cs   = pinsel_t'(map[15:8]);
   assign dout = pinsel_t'(map[23:16]);
   assign din  = pinsel_t'(map[31:24]);

   for (genvar g = 0; g < N_SIG; g++) begin : g_p0
      assign hit_p0[g] = (map[8*g +: 8] == 8'h00);
   end

   assign map_on_p0 = |hit_p0;

endmodule

// File: rtl/boot_step_timer.sv
module boot_step_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);

   if (TMO_W < 2 || TMO_W > 32) begin : g_chk_w
      $error("boot_step_timer: TMO_W out of range");
   end

   logic [TMO_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (run) cnt <= cnt + 1'b1;
      else cnt <= '0;
   end

   assign expire = run && (limit != '0) && (cnt == limit - 1'b1);

   // R5
   cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && limit != '0 && $stable(limit)) |-> (cnt < limit));

endmodule

// File: rtl/boot_order_map.sv
module boot_order_map
   import boot_scan_pkg::*;
#(
   parameter bit CUSTOM_EN = 1'b1
) (
   input  logic              custom,
   input  logic [PATH_W-1:0] uart_path,
   input  logic [IDX_W-1:0]  idx,
   output logic [PATH_W-1:0] path,
   output logic [IDX_W-1:0]  last_idx
);

   localparam logic [IDX_W-1:0] LAST_PLAIN = IDX_W'(5);
   localparam logic [IDX_W-1:0] LAST_CUST  = IDX_W'(7);

   logic [PATH_W-1:0] plain_path;
   assign plain_path = PATH_W'(idx + 1'b1);

   if (CUSTOM_EN) begin : g_cust
      always_comb begin
         if (!custom) begin
            path     = plain_path;
            last_idx = LAST_PLAIN;
         end else begin
            last_idx = LAST_CUST;
            if (idx == '0)               path = uart_path;
            else if (idx == IDX_W'(1))   path = P_SPI_CUST;
            else                         path = PATH_W'(idx - 1'b1);
         end
      end
   end else begin : g_plain
      logic unused_in;
      assign unused_in = custom ^ (|uart_path);
      assign path      = plain_path;
      assign last_idx  = LAST_PLAIN;
   end

endmodule

// File: rtl/boot_scan_seq.sv
module boot_scan_seq
   import boot_scan_pkg::*;
#(
   parameter int TMO_W     = 16,
   parameter bit CUSTOM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             app_flag_a,
   input  logic             app_flag_b,
   input  logic [31:0]      boot_cfg,
   input  logic [31:0]      pin_map,
   input  logic [TMO_W-1:0] step_timeout,
   input  logic             ld_done,
   input  logic             ld_fail,
   output logic             ld_en,
   output logic [2:0]       ld_path,
   output logic             cust_pins,
   output logic [3:0]       sck_port,
   output logic [3:0]       sck_pin,
   output logic [3:0]       cs_port,
   output logic [3:0]       cs_pin,
   output logic [3:0]       dout_port,
   output logic [3:0]       dout_pin,
   output logic [3:0]       din_port,
   output logic [3:0]       din_pin,
   output logic [7:0]       wake_op,
   output logic [7:0]       spi_div,
   output logic             rst_pin_en,
   output logic             dbg_en,
   output logic             boot_local,
   output logic             boot_done,
   output logic             halted,
   output logic             start_exec
);

   if (TMO_W < 2 || TMO_W > 32) begin : g_chk_w
      $error("boot_scan_seq: TMO_W out of range");
   end

   state_e            state;
   logic [IDX_W-1:0]  idx;
   logic [31:0]       cfg_q;
   logic [31:0]       map_q;
   logic              local_q;
   logic              start_q;

   logic              custom;
   logic [PATH_W-1:0] uart_path;
   logic              map_on_p0;
   pinsel_t           sck, cs, dout, din;
   logic [PATH_W-1:0] cur_path;
   logic [IDX_W-1:0]  last_idx;
   logic              expire;
   logic              attempt;
   logic              step_fail;
   logic              pad0_busy;

   boot_cfg_decode u_dec (
      .cfg       (cfg_q),
      .map       (map_q),
      .custom    (custom),
      .uart_path (uart_path),
      .wake_op   (wake_op),
      .spi_div   (spi_div),
      .sck       (sck),
      .cs        (cs),
      .dout      (dout),
      .din       (din),
      .map_on_p0 (map_on_p0)
   );

   boot_order_map #(.CUSTOM_EN(CUSTOM_EN)) u_order (
      .custom    (custom),
      .uart_path (uart_path),
      .idx       (idx),
      .path      (cur_path),
      .last_idx  (last_idx)
   );

   boot_step_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (attempt),
      .limit  (step_timeout),
      .expire (expire)
   );

   assign attempt   = (state == S_ATTEMPT);
   assign step_fail = attempt && !ld_done && (ld_fail || expire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_SAMPLE;
         idx     <= '0;
         cfg_q   <= '0;
         map_q   <= '0;
         local_q <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (state)
            S_SAMPLE: begin
               cfg_q   <= boot_cfg;
               map_q   <= pin_map;
               local_q <= app_flag_a & app_flag_b;
               idx     <= '0;
               if (app_flag_a & app_flag_b) begin
                  state   <= S_DONE;
                  start_q <= 1'b1;
               end else begin
                  state <= S_ATTEMPT;
               end
            end
            S_ATTEMPT: begin
               if (ld_done) begin
                  state   <= S_DONE;
                  start_q <= 1'b1;
               end else if (step_fail) begin
                  if (idx == last_idx) state <= S_HALT;
                  else begin
                     state <= S_GAP;
                     idx   <= idx + 1'b1;
                  end
               end
            end
            S_GAP:   state <= S_ATTEMPT;
            default: state <= state;
         endcase
      end
   end

   always_comb begin
      unique case (cur_path)
         P_SPI_HOST, P_UART2, P_SPI_DEV: pad0_busy = 1'b1;
         P_SPI_CUST:                     pad0_busy = map_on_p0;
         default:                        pad0_busy = 1'b0;
      endcase
   end

   assign ld_en      = attempt;
   assign ld_path    = attempt ? cur_path : P_NONE;
   assign cust_pins  = attempt && (cur_path == P_SPI_CUST);
   assign rst_pin_en = !(attempt && pad0_busy);
   assign dbg_en     = (state == S_HALT);
   assign halted     = (state == S_HALT);
   assign boot_done  = (state == S_DONE);
   assign boot_local = local_q;
   assign start_exec = start_q;

   assign sck_port  = sck.port;
   assign sck_pin   = sck.pin;
   assign cs_port   = cs.port;
   assign cs_pin    = cs.pin;
   assign dout_port = dout.port;
   assign dout_pin  = dout.pin;
   assign din_port  = din.port;
   assign din_pin   = din.pin;

   // R6
   start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_exec |=> !start_exec);

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> (boot_done && !ld_en));

   // R4
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && dbg_en && !ld_en));

   // R11
   pad0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_pin_en |-> ld_en);

   // R12
   gap_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_fail && !ld_done) |=> !ld_en);

   // R13
   done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_done) |=> (boot_done && start_exec));

   // R2
   local_no_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_local |-> !ld_en);

endmodule

// File: tb/boot_scan_seq_tb.sv
module boot_scan_seq_tb;

   localparam int CLK_P = 10;
   localparam int TW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          app_flag_a = 1'b0, app_flag_b = 1'b0;
   logic [31:0]   boot_cfg = '0, pin_map = '0;
   logic [TW-1:0] step_timeout = '0;
   logic          ld_done = 1'b0, ld_fail = 1'b0;

   logic       ld_en, cust_pins, rst_pin_en, dbg_en, boot_local, boot_done, halted, start_exec;
   logic [2:0] ld_path;
   logic [3:0] sck_port, sck_pin, cs_port, cs_pin, dout_port, dout_pin, din_port, din_pin;
   logic [7:0] wake_op, spi_div;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   boot_scan_seq #(.TMO_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .app_flag_a(app_flag_a), .app_flag_b(app_flag_b),
      .boot_cfg(boot_cfg), .pin_map(pin_map), .step_timeout(step_timeout),
      .ld_done(ld_done), .ld_fail(ld_fail), .ld_en(ld_en), .ld_path(ld_path),
      .cust_pins(cust_pins), .sck_port(sck_port), .sck_pin(sck_pin),
      .cs_port(cs_port), .cs_pin(cs_pin), .dout_port(dout_port), .dout_pin(dout_pin),
      .din_port(din_port), .din_pin(din_pin), .wake_op(wake_op), .spi_div(spi_div),
      .rst_pin_en(rst_pin_en), .dbg_en(dbg_en), .boot_local(boot_local),
      .boot_done(boot_done), .halted(halted), .start_exec(start_exec)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start(input logic fa, input logic fb, input logic [31:0] cfg,
                        input logic [31:0] map, input logic [TW-1:0] tmo);
      @(negedge clk);
      rst_n = 1'b0;
      app_flag_a = fa; app_flag_b = fb;
      boot_cfg = cfg; pin_map = map; step_timeout = tmo;
      ld_done = 1'b0; ld_fail = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // resp: 0 fail, 1 done, 2 timeout, 3 done and fail together
   task automatic attempt(input logic [2:0] exp_code, input logic exp_rst, input int resp);
      int n = 0;
      while (!ld_en && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk(ld_en, "R3 attempt enable", ld_en, 1);
      chk(ld_path == exp_code, "R3 path order", ld_path, exp_code);
      chk(rst_pin_en == exp_rst, "R11 pad0 reset gate", rst_pin_en, exp_rst);
      chk(cust_pins == (exp_code == 3'd7), "R7 cust_pins", cust_pins, exp_code == 3'd7);
      case (resp)
         0: begin
            ld_fail = 1'b1;
            @(negedge clk);
            ld_fail = 1'b0;
            chk(!ld_en, "R12 gap after fail", ld_en, 0);
            chk(rst_pin_en, "R11 gate released", rst_pin_en, 1);
         end
         1, 3: begin
            ld_done = 1'b1;
            ld_fail = (resp == 3);
            @(negedge clk);
            ld_done = 1'b0;
            ld_fail = 1'b0;
            chk(boot_done, resp == 3 ? "R13 done wins" : "R6 boot_done", boot_done, 1);
            chk(start_exec, "R6 start pulse", start_exec, 1);
            chk(!ld_en, "R6 enable drops", ld_en, 0);
            @(negedge clk);
            chk(!start_exec, "R6 pulse one cycle", start_exec, 0);
         end
         default: begin
            int c = 1;
            @(negedge clk);
            while (ld_en && c < 1000) begin
               c++;
               @(negedge clk);
            end
            chk(c == int'(step_timeout), "R5 timeout length", c, step_timeout);
         end
      endcase
   endtask

   task automatic expect_halt();
      chk(halted && dbg_en, "R4 halt with debug", {halted, dbg_en}, 3);
      repeat (3) @(negedge clk);
      chk(halted && dbg_en && !ld_en, "R4 halt holds", {halted, dbg_en, ld_en}, 6);
   endtask

   task automatic t_reset();
      start(1'b0, 1'b0, 32'h0000_00FF, 32'h0, 16'd0);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!ld_en && ld_path == 0 && !start_exec && !boot_done && !halted && !dbg_en && rst_pin_en,
          "R1 reset state", {ld_en, start_exec, boot_done, halted, dbg_en, rst_pin_en}, 1);
   endtask

   task automatic t_local();
      start(1'b1, 1'b1, 32'h0000_00FF, 32'h0, 16'd0);
      @(negedge clk);
      chk(boot_done && boot_local && start_exec, "R2 local boot",
          {boot_done, boot_local, start_exec}, 7);
      @(negedge clk);
      chk(!start_exec, "R2 single pulse", start_exec, 0);
      repeat (5) @(negedge clk);
      chk(!ld_en && boot_done, "R2 no scan", {ld_en, boot_done}, 1);
   endtask

   task automatic t_all_fail();
      start(1'b1, 1'b0, 32'h0000_00FF, 32'h0, 16'd1000);
      attempt(3'd1, 1'b0, 0);
      attempt(3'd2, 1'b1, 0);
      attempt(3'd3, 1'b1, 0);
      attempt(3'd4, 1'b0, 0);
      attempt(3'd5, 1'b0, 0);
      attempt(3'd6, 1'b1, 0);
      expect_halt();
   endtask

   task automatic t_timeout();
      start(1'b0, 1'b1, 32'h0000_00FF, 32'h0, 16'd5);
      attempt(3'd1, 1'b0, 2);
      attempt(3'd2, 1'b1, 1);
      ld_fail = 1'b1;
      @(negedge clk);
      ld_fail = 1'b0;
      ld_done = 1'b1;
      @(negedge clk);
      ld_done = 1'b0;
      @(negedge clk);
      chk(boot_done && !ld_en && !start_exec && !halted, "R6 later responses ignored",
          {boot_done, ld_en, start_exec, halted}, 8);
   endtask

   task automatic t_custom_fallback();
      start(1'b0, 1'b0, 32'h014B_9FAA, 32'h3A21_5C76, 16'd1000);
      attempt(3'd3, 1'b1, 0);
      chk(wake_op == 8'h9F, "R10 wake opcode", wake_op, 8'h9F);
      chk(spi_div == 8'h4B, "R10 divider", spi_div, 8'h4B);
      chk({sck_port, sck_pin} == 8'h76, "R9 clock field", {sck_port, sck_pin}, 8'h76);
      chk({cs_port, cs_pin} == 8'h5C, "R9 enable field", {cs_port, cs_pin}, 8'h5C);
      chk({dout_port, dout_pin} == 8'h21, "R9 data out field", {dout_port, dout_pin}, 8'h21);
      chk({din_port, din_pin} == 8'h3A, "R9 data in field", {din_port, din_pin}, 8'h3A);
      attempt(3'd7, 1'b1, 0);
      // R8: full default order follows
      attempt(3'd1, 1'b0, 0);
      attempt(3'd2, 1'b1, 0);
      attempt(3'd3, 1'b1, 0);
      attempt(3'd4, 1'b0, 0);
      attempt(3'd5, 1'b0, 0);
      attempt(3'd6, 1'b1, 0);
      expect_halt();
   endtask

   task automatic t_custom_pad0();
      start(1'b0, 1'b0, 32'h0200_00AA, 32'h1200_3344, 16'd1000);
      attempt(3'd2, 1'b1, 0);
      attempt(3'd7, 1'b0, 1);
   endtask

   task automatic t_custom_other_uart();
      start(1'b1, 1'b0, 32'h3700_00AA, 32'h0, 16'd1000);
      attempt(3'd4, 1'b0, 1);
      start(1'b1, 1'b0, 32'h0000_00AA, 32'h0, 16'd1000);
      attempt(3'd4, 1'b0, 1);
   endtask

   task automatic t_other_sel();
      start(1'b0, 1'b0, 32'h0100_0055, 32'h0, 16'd1000);
      attempt(3'd1, 1'b0, 0);
      attempt(3'd2, 1'b1, 3);
   endtask

   task automatic t_no_timeout();
      start(1'b0, 1'b0, 32'h0000_00FF, 32'h0, 16'd0);
      attempt(3'd1, 1'b0, 3);
      start(1'b0, 1'b0, 32'h0000_00FF, 32'h0, 16'd0);
      repeat (45) @(negedge clk);
      chk(ld_en && ld_path == 3'd1, "R5 zero limit never expires", ld_path, 1);
      attempt(3'd1, 1'b0, 1);
   endtask

   initial begin
      t_reset();
      t_local();
      t_all_fail();
      t_timeout();
      t_custom_fallback();
      t_custom_pad0();
      t_custom_other_uart();
      t_other_sel();
      t_no_timeout();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule